// File: doc/BRIEF.md
# Limit Counter with Sticky Reached Flag

This block is a memory-mapped up-counter for timekeeping. Each cycle in which the tick-enable input is high advances the count by one step. The count is held in bits 30 to 9 of a 32-bit register word, so one step is worth 512 register units. When the next step would reach the programmed limit, the count returns to zero. At the same moment a sticky reached flag is set and the interrupt output is raised. A limit of zero selects free-running, and the counter then wraps at 0x7FFFFE00.

Software uses a word-addressed register port with three words. Word 0 is the limit. Writing it restarts the count, and reading it acknowledges the interrupt. Word 1 is the count, with the reached flag in bit 31. Word 2 is a second address for the limit: writing it loads the limit and the count carries on undisturbed. Read data is registered. It appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `limit_counter`

## Requirements
- R1: The count advances by exactly one step, at bit 9 of the register value, on each clock edge where tickEn is high, and holds otherwise. Bits 8 to 0 of every read value are zero.
- R2: A read of word 1 returns the reached flag in bit 31 and the count in bits 30 to 9. This read changes neither the count, the flag nor the interrupt.
- R3: A write to word 2 loads the limit and leaves the count unchanged.
- R4: A write to word 0 loads the limit, sets the count to zero and lowers the interrupt. It leaves the reached flag unchanged. When a tick falls in the same cycle, the write takes priority over the tick.
- R5: A read of word 0 returns the limit with bit 31 zero. As a side effect it clears the reached flag and lowers the interrupt.
- R6: When a tick would take the count up to the limit step, the count becomes zero, the reached flag is set and the interrupt is raised. The interrupt stays high until it is acknowledged.
- R7: Bits 8 to 0 and bit 31 of a written limit are discarded, so the limit is always a whole number of steps.
- R8: After reset the limit, the count, the reached flag, the interrupt and the read data are all zero, and the counter runs free.
- R9: A limit of zero selects free-running. The count then wraps after step 0x3FFFFF, which is register value 0x7FFFFE00, and no lower count raises the interrupt.
- R10: Reads of word addresses 3 and above return zero. Writes to them have no effect.
- R11: If a write to word 2 places the limit at or below the current count, the next tick wraps the count to zero and sets the reached flag.
- R12: If the limit is reached in the same cycle as a read of word 0, the flag and the interrupt end up set. A reach is never lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One count step per cycle while high |
| addr | input | ADDR_W | Word address of the register access |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe; read side effects occur on this edge |
| rdData | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, high from a reach until acknowledged |

## Verification
The main function is tried with three kinds of limit. A small nonzero limit shows the exact wrap step and the moment the flag and interrupt are raised. A limit changed through word 2 in mid-count separates the non-restarting load from the restarting one, both when the new limit lies above the count and when it lies below it. A zero limit shows that free-running raises no interrupt at counts past any earlier limit. Collisions in one cycle, a tick against a restarting write and a reach against an acknowledge, decide the priority rules. Accesses to undefined addresses are followed by reads of the limit and count words, to show that no state moved.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int unsigned WORD_LIMIT = 0;
  localparam int unsigned WORD_COUNT = 1;
  localparam int unsigned WORD_ALIAS = 2;

  typedef enum logic [1:0] {RD_NONE, RD_LIMIT, RD_COUNT} rdSel_e;

  typedef struct packed {
    logic   loadLimit;
    logic   clrCount;
    logic   ackIrq;
    logic   rdStrobe;
    rdSel_e rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrb_t         strb
);
  logic isLimit, isCount, isAlias;

  always_comb begin
    isLimit = (addr == ADDR_W'(WORD_LIMIT));
    isCount = (addr == ADDR_W'(WORD_COUNT));
    isAlias = (addr == ADDR_W'(WORD_ALIAS));

    strb.loadLimit = wrEn && (isLimit || isAlias);
    strb.clrCount  = wrEn && isLimit;
    strb.ackIrq    = rdEn && isLimit;
    strb.rdStrobe  = rdEn;
    if (rdEn && isLimit)      strb.rdSel = RD_LIMIT;
    else if (rdEn && isCount) strb.rdSel = RD_COUNT;
    else                      strb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/lc_datapath.sv
module lc_datapath
  import lc_pkg::*;
#(
  parameter int unsigned STEP_LSB = 9,
  parameter int unsigned STEP_W   = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  ctrlStrb_t         strb,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq,
  output logic [STEP_W-1:0] countStep
);
  localparam logic [STEP_W-1:0] FREE_TOP = '1;

  logic [STEP_W-1:0] limStep;
  logic [STEP_W-1:0] topStep;
  logic [STEP_W:0]   nextWide;
  logic              reachNow;
  logic              reached;

  always_comb begin
    topStep  = (limStep == '0) ? FREE_TOP : limStep;
    nextWide = {1'b0, countStep} + 1'b1;
    reachNow = tickEn && !strb.clrCount && (nextWide >= {1'b0, topStep});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limStep   <= '0;
      countStep <= '0;
    end else begin
      if (strb.loadLimit) limStep <= wrData[STEP_LSB +: STEP_W];
      if (strb.clrCount)  countStep <= '0;
      else if (reachNow)  countStep <= '0;
      else if (tickEn)    countStep <= nextWide[STEP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reached <= 1'b0;
      irq     <= 1'b0;
    end else if (reachNow) begin
      reached <= 1'b1;
      irq     <= 1'b1;
    end else if (strb.ackIrq) begin
      reached <= 1'b0;
      irq     <= 1'b0;
    end else if (strb.clrCount) begin
      irq     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdStrobe) begin
      case (strb.rdSel)
        RD_LIMIT: rdData <= {1'b0, limStep, {STEP_LSB{1'b0}}};
        RD_COUNT: rdData <= {reached, countStep, {STEP_LSB{1'b0}}};
        default:  rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/limit_counter.sv
module limit_counter
  import lc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned STEP_LSB = 9,
  parameter int unsigned STEP_W   = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  output logic [31:0]       rdData,
  output logic              irq
);
  ctrlStrb_t         strb;
  logic [STEP_W-1:0] countStep;

  lc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strb(strb)
  );

  lc_datapath #(.STEP_LSB(STEP_LSB), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb),
    .wrData(wrData), .rdData(rdData), .irq(irq), .countStep(countStep)
  );
endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned STEP_LSB = 9,
  parameter int unsigned STEP_W   = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [31:0]       rdData,
  input logic              irq,
  input logic [STEP_W-1:0] countStep
);
  p_low_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdData[STEP_LSB-1:0] == '0);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrEn) |=> $stable(countStep));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == '0) |=> (countStep == '0 && !irq));

  p_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == '0 && !tickEn) |=> !irq);

  p_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(tickEn) && countStep == '0));

  p_undef_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr > ADDR_W'(2)) |=> rdData == '0);
endmodule

bind limit_counter lc_checker #(.ADDR_W(ADDR_W), .STEP_LSB(STEP_LSB), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
  .rdEn(rdEn), .rdData(rdData), .irq(irq), .countStep(countStep)
);

// File: tb/sim_limit_counter.sv
module sim_limit_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  localparam logic [31:0] FLAG = 32'h8000_0000;

  always #2 clk = ~clk;

  limit_counter u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(posedge clk); #1;
    d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R8 irq", {31'b0, irq}, 32'h0);
    check("R8 rdData", rdData, 32'h0);
    rd(1, d); check("R8 count", d, 32'h0);
    rd(0, d); check("R8 limit", d, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    wr(0, 32'h0000_0A00);
    tick(3);
    rd(1, d); check("R1 count 3 steps", d, 32'h600);
    check("R6 no irq before limit", {31'b0, irq}, 32'h0);
    tick(2);
    check("R6 irq at limit", {31'b0, irq}, 32'h1);
    rd(1, d); check("R6 wrapped with flag", d, FLAG);
    rd(1, d); check("R2 count read keeps flag", d, FLAG);
    check("R2 count read keeps irq", {31'b0, irq}, 32'h1);
    rd(0, d); check("R5 limit value", d, 32'h0000_0A00);
    check("R5 irq cleared", {31'b0, irq}, 32'h0);
    rd(1, d); check("R5 flag cleared", d, 32'h0);
  endtask

  task automatic t_trunc();
    logic [31:0] d;
    wr(0, 32'h0000_0BFF);
    rd(0, d); check("R7 low bits dropped", d, 32'h0000_0A00);
    wr(0, 32'h8000_0A00);
    rd(0, d); check("R7 bit31 dropped", d, 32'h0000_0A00);
  endtask

  task automatic t_alias_up();
    logic [31:0] d;
    wr(0, 32'h0000_1400);
    tick(4);
    wr(2, 32'h0000_1000);
    rd(1, d); check("R3 count kept", d, 32'h800);
    rd(0, d); check("R3 limit loaded", d, 32'h1000);
    tick(4);
    rd(1, d); check("R3 wraps at new limit", d, FLAG);
    rd(0, d);
  endtask

  task automatic t_alias_below();
    logic [31:0] d;
    wr(0, 32'h0000_1400);
    tick(6);
    wr(2, 32'h0000_0800);
    rd(1, d); check("R11 count above limit held", d, 32'hC00);
    tick(1);
    rd(1, d); check("R11 next tick wraps", d, FLAG);
    check("R11 irq", {31'b0, irq}, 32'h1);
    wr(0, 32'h0000_1400);
    check("R4 write drops irq", {31'b0, irq}, 32'h0);
    rd(1, d); check("R4 flag kept, count zero", d, FLAG);
    rd(0, d);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(0, 32'h0000_0600);
    tick(1);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'd0; wrData = 32'h0000_0600; tickEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    rd(1, d); check("R4 restart beats tick", d, 32'h0);
    tick(2);
    @(negedge clk);
    rdEn = 1'b1; addr = 3'd0; tickEn = 1'b1;
    @(posedge clk); #1;
    d = rdData;
    @(negedge clk);
    rdEn = 1'b0; tickEn = 1'b0;
    check("R12 limit read value", d, 32'h600);
    check("R12 irq survives ack", {31'b0, irq}, 32'h1);
    rd(1, d); check("R12 flag survives ack", d, FLAG);
    rd(0, d);
  endtask

  task automatic t_undef();
    logic [31:0] d;
    wr(0, 32'h0000_2000);
    tick(2);
    for (int a = 3; a < 8; a++) begin
      rd(3'(a), d); check("R10 undefined read", d, 32'h0);
      wr(3'(a), 32'hFFFF_FFFF);
    end
    rd(0, d); check("R10 limit untouched", d, 32'h2000);
    rd(1, d); check("R10 count untouched", d, 32'h400);
    check("R10 irq untouched", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_hold_free();
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rd(1, d); check("R1 count holds without tick", d, 32'h400);
    wr(0, 32'h0);
    tick(300);
    rd(1, d); check("R9 free-run count", d, 32'd300 << 9);
    check("R9 no irq", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_trunc();
    t_alias_up();
    t_alias_below();
    t_priority();
    t_undef();
    t_hold_free();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule